// File: doc/BRIEF.md
# Post Divider and Test Output Selector

This block sits behind a frequency synthesizer's loop. It holds the feedback M counter, the N post divider, which feeds the main clock output, and a multiplexer that places one internal node or a constant level on a single-ended test pin. The post divider halves its source once more, so the main output runs at the source rate divided by 2·N, where N is a power of two chosen by a 2-bit code. The M counter gives a narrow pulse once every M source cycles.

A 3-bit test code picks what the test pin shows. One code puts the block into a bypass debug mode. In that mode the serial clock drives both dividers in place of the oscillator. The main output then runs at a rate set by software, and the test pin carries the M counter pulse. The whole block runs on the oscillator clock. The reference and serial clocks are synchronized and used as edge strobes, so in bypass mode a serial clock rising edge enables one divider step. New N and T codes are held off until the main output completes a period, so a code change never shortens a high or low phase.

Top module: `postdiv_testsel`

## Requirements
- R1: While `rst_n` is low, `fout` and `test_out` are 0. After release, the test code in force is 000 and the divide code in force is ÷1. Both stay so until the first falling edge of `fout`, so the first high phase of `fout` lasts exactly one oscillator cycle.
- R2: Outside bypass, `n_code` value k gives a `fout` period of 2·2^k oscillator cycles, with a high phase of 2^k cycles (00→÷1, 01→÷2, 10→÷4, 11→÷8, each then halved once more).
- R3: With test code 011, `test_out` is high for one source cycle in every M source cycles, where M is `m_val`. An `m_val` of 0 or 1 acts as 2.
- R4: Test code 001 drives `test_out` to 1, and test code 101 drives it to 0.
- R5: Test code 000 puts `ser_shift_out` on `test_out`, one oscillator cycle later.
- R6: Test code 010 puts the reference clock divided by 16 on `test_out`. The high phase lasts 8 reference periods and the low phase 8.
- R7: Test code 100 puts `fout` on `test_out`. Test code 111 puts `fout` divided by 4 on `test_out`, with a 50% duty cycle.
- R8: With test code 110, each synchronized rising edge of `ser_clk` is one source cycle for both dividers. `fout` has a period of 2·N serial periods. `test_out` carries the M pulse, which is high for one serial period in every M.
- R9: Outside bypass, `ser_clk` has no effect on `fout` or on the M pulse.
- R10: A new `n_code` or `t_code` is taken only at the falling edge of `fout`. Every complete high or low phase of `fout` lasts either the old half period or the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; clocks all state |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_clk | input | 1 | Reference clock, sampled as a level |
| ser_clk | input | 1 | Serial clock, sampled as a level; the divider source in bypass |
| ser_shift_out | input | 1 | Last bit of the serial configuration shift register |
| m_val | input | M_W (9) | Feedback count M |
| n_code | input | N_W (2) | Post divider code, divide by 2^code |
| t_code | input | 3 | Test output selection |
| fout | output | 1 | Main divided clock |
| test_out | output | 1 | Selected test node |

## Verification
The hardest case is a divide code change that lands mid-period. Whether a runt appears depends on the divider's phase at the instant the code changes, and that phase cannot be seen at the ports. The stimulus holds a slow setting and changes the code at each of eight consecutive oscillator cycles. It measures every complete high and low phase around each change. The bypass mode is also awkward. Entering and leaving it both wait for a falling edge of `fout` under the old source, so the serial clock runs during the whole run, and each setting is given time to reach its terminal count before any measurement.

// File: rtl/pdts_pkg.sv
package pdts_pkg;

  localparam int TSEL_W = 3;

  // Test pin selections; TS_BYPASS also reroutes the divider source.
  typedef enum logic [TSEL_W-1:0] {
    TS_SHIFT  = 3'b000,
    TS_ONE    = 3'b001,
    TS_REFDIV = 3'b010,
    TS_MCNT   = 3'b011,
    TS_FOUT   = 3'b100,
    TS_ZERO   = 3'b101,
    TS_BYPASS = 3'b110,
    TS_FOUT4  = 3'b111
  } tsel_e;

endpackage

// File: rtl/pdts_rst_sync.sv
module pdts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/pdts_edge_sync.sv
module pdts_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_in};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/pdts_mcount.sv
module pdts_mcount #(
  parameter int M_W = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [M_W-1:0] m_val,
  output logic           pulse
);

  localparam logic [M_W-1:0] M_FLOOR = M_W'(2);

  logic [M_W-1:0] m_eff;
  logic [M_W-1:0] cnt_q, cnt_d;
  logic           pls_q, pls_d;

  assign m_eff = (m_val < M_FLOOR) ? M_FLOOR : m_val;

  always_comb begin
    cnt_d = cnt_q;
    pls_d = pls_q;
    if (tick) begin
      if (cnt_q >= m_eff - 1'b1) begin
        cnt_d = '0;
        pls_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
        pls_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pls_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pls_q <= pls_d;
    end
  end

  assign pulse = pls_q;

endmodule

// File: rtl/pdts_postdiv.sv
module pdts_postdiv #(
  parameter int N_W = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [N_W-1:0] n_code,
  output logic           fout,
  output logic           fout_rise,
  output logic           term,
  output logic [N_W-1:0] n_act
);

  localparam int LOG_HALF_MAX = (1 << N_W) - 1;
  localparam int CNT_W        = (LOG_HALF_MAX > 0) ? LOG_HALF_MAX : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] half_m1;
  logic             out_q, out_d;
  logic [N_W-1:0]   n_q, n_d;
  logic             at_end;

  // half period minus one: 2^n - 1
  assign half_m1 = ~({CNT_W{1'b1}} << n_q);
  assign at_end  = (cnt_q >= half_m1);

  always_comb begin
    cnt_d     = cnt_q;
    out_d     = out_q;
    n_d       = n_q;
    fout_rise = 1'b0;
    term      = 1'b0;
    if (tick) begin
      if (at_end) begin
        cnt_d = '0;
        out_d = ~out_q;
        if (out_q) begin
          term = 1'b1;
          n_d  = n_code;
        end else begin
          fout_rise = 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
      n_q   <= '0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
      n_q   <= n_d;
    end
  end

  assign fout  = out_q;
  assign n_act = n_q;

endmodule

// File: rtl/pdts_testsel.sv
module pdts_testsel
  import pdts_pkg::*;
#(
  parameter int REF_DIV_W  = 4,
  parameter int FOUT_DIV_W = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ref_rise,
  input  logic  fout_rise,
  input  tsel_e t_act,
  input  logic  shift_bit,
  input  logic  m_pulse,
  input  logic  fout,
  output logic  test_out
);

  logic [REF_DIV_W-1:0]  ref_cnt_q, ref_cnt_d;
  logic [FOUT_DIV_W-1:0] fdiv_q, fdiv_d;
  logic                  sel_d, sel_q;

  always_comb begin
    ref_cnt_d = ref_cnt_q;
    fdiv_d    = fdiv_q;
    if (ref_rise)  ref_cnt_d = ref_cnt_q + 1'b1;
    if (fout_rise) fdiv_d    = fdiv_q + 1'b1;
  end

  always_comb begin
    unique case (t_act)
      TS_SHIFT:           sel_d = shift_bit;
      TS_ONE:             sel_d = 1'b1;
      TS_REFDIV:          sel_d = ref_cnt_q[REF_DIV_W-1];
      TS_MCNT, TS_BYPASS: sel_d = m_pulse;
      TS_FOUT:            sel_d = fout;
      TS_ZERO:            sel_d = 1'b0;
      TS_FOUT4:           sel_d = fdiv_q[FOUT_DIV_W-1];
      default:            sel_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt_q <= '0;
      fdiv_q    <= '0;
      sel_q     <= 1'b0;
    end else begin
      ref_cnt_q <= ref_cnt_d;
      fdiv_q    <= fdiv_d;
      sel_q     <= sel_d;
    end
  end

  assign test_out = sel_q;

endmodule

// File: rtl/postdiv_testsel.sv
module postdiv_testsel
  import pdts_pkg::*;
#(
  parameter int M_W         = 9,
  parameter int N_W         = 2,
  parameter int REF_DIV_W   = 4,
  parameter int FOUT_DIV_W  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic              ref_clk,
  input  logic              ser_clk,
  input  logic              ser_shift_out,
  input  logic [M_W-1:0]    m_val,
  input  logic [N_W-1:0]    n_code,
  input  logic [TSEL_W-1:0] t_code,
  output logic              fout,
  output logic              test_out
);

  localparam int NUM_ASYNC = 2;
  localparam int IDX_REF   = 0;
  localparam int IDX_SER   = 1;

  logic                 rst_sync_n;
  logic [NUM_ASYNC-1:0] async_vec;
  logic [NUM_ASYNC-1:0] rise_vec;
  tsel_e                t_act_q, t_act_d;
  logic                 bypass;
  logic                 src_tick;
  logic                 term;
  logic                 fout_rise;
  logic                 m_pulse;
  logic [N_W-1:0]       n_act;

  pdts_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (osc_clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  assign async_vec[IDX_REF] = ref_clk;
  assign async_vec[IDX_SER] = ser_clk;

  for (genvar g = 0; g < NUM_ASYNC; g++) begin : g_sync
    pdts_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (osc_clk),
      .rst_n    (rst_sync_n),
      .async_in (async_vec[g]),
      .rise     (rise_vec[g])
    );
  end

  // test code is adopted at the same terminal count as the divide code
  always_comb begin
    t_act_d = t_act_q;
    if (term) t_act_d = tsel_e'(t_code);
  end

  always_ff @(posedge osc_clk or negedge rst_sync_n) begin
    if (!rst_sync_n) t_act_q <= TS_SHIFT;
    else             t_act_q <= t_act_d;
  end

  assign bypass   = (t_act_q == TS_BYPASS);
  assign src_tick = bypass ? rise_vec[IDX_SER] : 1'b1;

  pdts_mcount #(.M_W(M_W)) u_mcount (
    .clk   (osc_clk),
    .rst_n (rst_sync_n),
    .tick  (src_tick),
    .m_val (m_val),
    .pulse (m_pulse)
  );

  pdts_postdiv #(.N_W(N_W)) u_postdiv (
    .clk       (osc_clk),
    .rst_n     (rst_sync_n),
    .tick      (src_tick),
    .n_code    (n_code),
    .fout      (fout),
    .fout_rise (fout_rise),
    .term      (term),
    .n_act     (n_act)
  );

  pdts_testsel #(
    .REF_DIV_W  (REF_DIV_W),
    .FOUT_DIV_W (FOUT_DIV_W)
  ) u_testsel (
    .clk       (osc_clk),
    .rst_n     (rst_sync_n),
    .ref_rise  (rise_vec[IDX_REF]),
    .fout_rise (fout_rise),
    .t_act     (t_act_q),
    .shift_bit (ser_shift_out),
    .m_pulse   (m_pulse),
    .fout      (fout),
    .test_out  (test_out)
  );

endmodule

// File: rtl/pdts_chk.sv
module pdts_chk #(
  parameter int N_W = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           fout,
  input logic           test_out,
  input logic           m_pulse,
  input logic [2:0]     t_act,
  input logic [N_W-1:0] n_act
);

  logic byp;
  assign byp = (t_act == 3'b110);

  // R3
  m_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byp && m_pulse) |=> (byp || !m_pulse));

  // R8
  fout_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(fout));

  // R4
  const_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_act == 3'b001) |=> test_out);

  // R4
  const_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_act == 3'b101) |=> !test_out);

  // R10
  t_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(t_act) |-> $fell(fout));

  // R10
  n_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(n_act) |-> $fell(fout));

endmodule

bind postdiv_testsel pdts_chk #(.N_W(N_W)) i_pdts_chk (
  .clk      (osc_clk),
  .rst_n    (rst_sync_n),
  .tick     (src_tick),
  .fout     (fout),
  .test_out (test_out),
  .m_pulse  (m_pulse),
  .t_act    (t_act_q),
  .n_act    (n_act)
);

// File: tb/test_postdiv_testsel.sv
module test_postdiv_testsel;

  typedef struct packed {
    logic [1:0] n;
    logic [8:0] m;
    logic [2:0] t;
    int         fp;   // fout period, 0 = skip
    int         fh;   // fout high cycles
    int         tp;   // test period, 0 = constant level th
    int         th;   // test high cycles or constant level
    int         req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 9'd5, 3'b100,   2,  1,   2,  1, 2},  // R2 R7 R9
    '{2'd1, 9'd5, 3'b100,   4,  2,   4,  2, 2},  // R2
    '{2'd2, 9'd5, 3'b100,   8,  4,   8,  4, 2},  // R2
    '{2'd3, 9'd5, 3'b100,  16,  8,  16,  8, 7},  // R7
    '{2'd1, 9'd7, 3'b011,   4,  2,   7,  1, 3},  // R3
    '{2'd0, 9'd0, 3'b011,   2,  1,   2,  1, 3},  // R3 clamp
    '{2'd0, 9'd1, 3'b011,   2,  1,   2,  1, 3},  // R3 clamp
    '{2'd0, 9'd9, 3'b011,   2,  1,   9,  1, 9},  // R9
    '{2'd2, 9'd3, 3'b111,   8,  4,  32, 16, 7},  // R7
    '{2'd0, 9'd3, 3'b010,   2,  1,  96, 48, 6},  // R6
    '{2'd1, 9'd4, 3'b110,  32, 16,  32,  8, 8},  // R8
    '{2'd0, 9'd4, 3'b001,   2,  1,   0,  1, 4},  // R4
    '{2'd3, 9'd2, 3'b110, 128, 64,  16,  8, 8},  // R8
    '{2'd1, 9'd6, 3'b101,   4,  2,   0,  0, 4},  // R4
    '{2'd2, 9'd3, 3'b011,   8,  4,   3,  1, 3}   // R3
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk = 1'b0;
  logic       ser_clk = 1'b0;
  logic       shift_bit = 1'b0;
  logic [8:0] m_val = 9'd5;
  logic [1:0] n_code = 2'd2;
  logic [2:0] t_code = 3'b000;
  logic       fout;
  logic       test_out;

  int n_chk = 0;
  int n_fail = 0;

  always #4  clk = ~clk;       // 125 MHz
  always #24 ref_clk = ~ref_clk;
  always #32 ser_clk = ~ser_clk;

  postdiv_testsel i_postdiv_testsel (
    .osc_clk       (clk),
    .rst_n         (rst_n),
    .ref_clk       (ref_clk),
    .ser_clk       (ser_clk),
    .ser_shift_out (shift_bit),
    .m_val         (m_val),
    .n_code        (n_code),
    .t_code        (t_code),
    .fout          (fout),
    .test_out      (test_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit pick(input bit use_test);
    return use_test ? test_out : fout;
  endfunction

  task automatic measure(input bit use_test, output int hi, output int per,
                         output bit ok);
    int  guard;
    int  lo;
    bit  s;
    bit  p;
    ok = 1'b1; hi = 0; per = 0; guard = 0;
    @(negedge clk);
    p = pick(use_test);
    forever begin
      @(negedge clk);
      s = pick(use_test);
      if (s && !p) break;
      p = s;
      guard++;
      if (guard > 3000) begin ok = 1'b0; return; end
    end
    hi = 1;
    forever begin
      @(negedge clk);
      if (!pick(use_test)) break;
      hi++;
      if (hi > 3000) begin ok = 1'b0; return; end
    end
    lo = 1;
    forever begin
      @(negedge clk);
      if (pick(use_test)) break;
      lo++;
      if (lo > 3000) begin ok = 1'b0; return; end
    end
    per = hi + lo;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int  hi;
    int  per;
    bit  ok;
    int  bad;
    int  run;
    bit  prev;
    bit  started;
    vec_t v;
    string rq;

    // R1 reset state
    repeat (5) @(negedge clk);
    check(fout == 1'b0 && test_out == 1'b0, "R1", "outputs low in reset",
          {30'd0, fout, test_out}, 0);
    rst_n = 1'b1;

    // R1 first high phase uses divide-by-1 until the first fall
    measure(1'b0, hi, per, ok);
    check(ok && hi == 1, "R1", "first fout high phase", hi, 1);
    // R2 then n_code 10 applies
    measure(1'b0, hi, per, ok);
    check(ok && hi == 4 && per == 8, "R2", "fout period after first fall", per, 8);

    // R5 shift bit follows with one cycle latency (T=000 after reset, R1)
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      shift_bit = ((8'b1011_0010 >> i) & 8'd1) != 0;
      @(negedge clk);
      check(test_out == shift_bit, "R5", "shift bit on test pin",
            int'(test_out), int'(shift_bit));
    end

    // table walk: R2 R3 R4 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      rq = $sformatf("R%0d", v.req);
      @(negedge clk);
      n_code = v.n; m_val = v.m; t_code = v.t;
      repeat (300) @(negedge clk);
      if (v.fp != 0) begin
        measure(1'b0, hi, per, ok);
        check(ok && per == v.fp, rq, $sformatf("vec %0d fout period", i), per, v.fp);
        check(ok && hi == v.fh, rq, $sformatf("vec %0d fout high", i), hi, v.fh);
      end
      if (v.tp != 0) begin
        measure(1'b1, hi, per, ok);
        check(ok && per == v.tp, rq, $sformatf("vec %0d test period", i), per, v.tp);
        check(ok && hi == v.th, rq, $sformatf("vec %0d test high", i), hi, v.th);
      end else begin
        bad = 0;
        repeat (50) begin
          @(negedge clk);
          if (test_out !== v.th[0]) bad++;
        end
        check(bad == 0, rq, $sformatf("vec %0d constant level misses", i), bad, 0);
      end
    end

    // R10 divide change at every phase of a slow period: no runt phases
    @(negedge clk);
    t_code = 3'b100; n_code = 2'd3;
    repeat (100) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      bad = 0; run = 0; started = 1'b0; prev = fout;
      for (int c = 0; c < 100; c++) begin
        @(negedge clk);
        if (c == k) n_code = 2'd1;
        if (fout != prev) begin
          if (started && run != 8 && run != 2) bad = run;
          started = 1'b1;
          run = 1;
          prev = fout;
        end else begin
          run++;
        end
      end
      check(bad == 0, "R10", $sformatf("phase %0d odd run length", k), bad, 0);
      n_code = 2'd3;
      repeat (60) @(negedge clk);
    end

    summary();
    $finish;
  end

endmodule